// File: doc/BRIEF.md
# Field-Typed Control/Status Register Bank

This block is a bank of four 32-bit registers that sits between a simple chip-select bus and the logic it controls. Each register is divided into fields. Every field has an access type: read-write, read-only or write-only. Some bus-writable fields are also pulses that clear themselves. The bus side writes registers in one clock and reads them combinationally. The logic side receives the current value of every bus-writable field and a one-cycle strobe per register whenever the bus writes it. The logic side can also load read-only fields through per-field load/value pairs.

The field layout, the reset constants and the requested addresses live in a package. Registers with no requested address take the lowest free word-aligned address, and the search starts at zero. With the default table, the status register asks for 0x0 and the extension scratch register asks for 0x10. The control register is then placed at 0x4 and the command register at 0x8, which leaves 0xC unmapped.

Top module: `csr_bank`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, the registers hold their reset constants: control 0x0000_0050, status 0x0000_0100, command 0x0000_0000, scratch 0xDEAD_BEEF.
- R2: Registers are decoded by an exact 32-bit address match: status at 0x0, control at 0x4, command at 0x8, scratch at 0x10. At most one register is selected for any address.
- R3: A bus write (`cs_i`=1, `rnw_i`=0) to a mapped address copies `wdata_i` into the addressed register's bus-writable bits only. These are control bits 0, 7:4 and 31:16, command bits 16:0, and all of scratch. All other bits keep their value, and nothing changes when `cs_i`=0.
- R4: Read-only fields (status bits 7:0 and bit 8) ignore bus writes, and the status register's other bits stay 0.
- R5: `hw_wstb_o[r]` is 1 for exactly the one cycle after the edge that performs a bus write to register r (index 0 control, 1 status, 2 command, 3 scratch). It is 0 otherwise. The status register's strobe never rises.
- R6: Control bit 0 and command bit 16 clear themselves. A written 1 stays visible for exactly one cycle, then reads back as 0 unless it is written again.
- R7: When `hw_ld_i[f]` is 1 for a read-only field f (f=3: status bits 7:0; f=4: status bit 8), the low bits of `hw_ld_val_i[f]` are loaded into that field on the clock edge. Value bits above the field width are dropped. The load takes effect even in a cycle with a bus write to the same register. Load requests for the other fields are ignored.
- R8: `rdata_o` is combinational. When `cs_i`=1 and `rnw_i`=1 at a mapped address, it shows that register's readable bits (read-write and read-only fields). Write-only and unused bits read as 0, and `rdata_o` is 0 whenever no read is decoded.
- R9: `hw_val_o[r]` shows register r's bus-writable bits continuously, and its other bits are 0.
- R10: A read or write to an unmapped address (for example 0xC or 0x14) changes no register, raises no strobe and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Bus address |
| cs_i | input | 1 | Chip select |
| rnw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data (combinational) |
| hw_val_o | output | 4x32 | Bus-writable bits per register, other bits 0 |
| hw_wstb_o | output | 4 | One-cycle bus-write strobe per register |
| hw_ld_i | input | 8 | Per-field load request from logic |
| hw_ld_val_i | input | 8x32 | Per-field load value, right aligned |

## Verification
Some properties are checked on every cycle. Self-clearing bits drop after any cycle without a write. The strobe follows the registered write enable. Non-writable bits stay stable when no load is requested. At most one register decodes, and read data is zero when no read is requested. Other behaviours can only be shown by scenarios against a bench model: the address placement, merging a write with a simultaneous load, truncation of load values, write-only bits reading as zero, and unmapped accesses leaving all state untouched.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int DW   = 32;
  localparam int AW   = 32;
  localparam int NREG = 4;
  localparam int NFLD = 8;
  localparam int ASTEP = DW / 8;

  typedef enum logic [1:0] {ACC_RW, ACC_RO, ACC_WO} acc_e;

  localparam logic [AW-1:0] ADDR_AUTO = '1;

  // field table
  localparam int   FLD_REG [NFLD] = '{0, 0, 0, 1, 1, 2, 2, 3};
  localparam int   FLD_LSB [NFLD] = '{0, 4, 16, 0, 8, 0, 16, 0};
  localparam int   FLD_W   [NFLD] = '{1, 4, 16, 8, 1, 16, 1, 32};
  localparam acc_e FLD_ACC [NFLD] = '{ACC_RW, ACC_RW, ACC_RW, ACC_RO, ACC_RO,
                                      ACC_WO, ACC_WO, ACC_RW};
  localparam bit   FLD_SC  [NFLD] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0,
                                      1'b0, 1'b1, 1'b0};

  localparam logic [DW-1:0] REG_RST  [NREG] = '{32'h0000_0050, 32'h0000_0100,
                                               32'h0000_0000, 32'hDEAD_BEEF};
  localparam logic [AW-1:0] REG_AREQ [NREG] = '{ADDR_AUTO, 32'h0000_0000,
                                               ADDR_AUTO, 32'h0000_0010};

  function automatic logic [DW-1:0] fld_mask(input int f);
    logic [2*DW-1:0] m;
    m = ((2*DW)'(1) << FLD_W[f]) - (2*DW)'(1);
    m = m << FLD_LSB[f];
    return m[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] wr_mask(input int r);
    logic [DW-1:0] m = '0;
    for (int f = 0; f < NFLD; f++)
      if (FLD_REG[f] == r && FLD_ACC[f] != ACC_RO) m |= fld_mask(f);
    return m;
  endfunction

  function automatic logic [DW-1:0] rd_mask(input int r);
    logic [DW-1:0] m = '0;
    for (int f = 0; f < NFLD; f++)
      if (FLD_REG[f] == r && FLD_ACC[f] != ACC_WO) m |= fld_mask(f);
    return m;
  endfunction

  function automatic logic [DW-1:0] sc_mask(input int r);
    logic [DW-1:0] m = '0;
    for (int f = 0; f < NFLD; f++)
      if (FLD_REG[f] == r && FLD_SC[f] && FLD_ACC[f] != ACC_RO) m |= fld_mask(f);
    return m;
  endfunction

  // lowest free word address, allocated in table order
  function automatic logic [AW-1:0] reg_addr(input int r);
    logic [AW-1:0] a [NREG];
    logic [AW-1:0] cand;
    logic          found, taken;
    for (int i = 0; i < NREG; i++) a[i] = REG_AREQ[i];
    for (int i = 0; i < NREG; i++) begin
      if (a[i] == ADDR_AUTO) begin
        found = 1'b0;
        for (int k = 0; k <= NREG; k++) begin
          cand  = AW'(k * ASTEP);
          taken = 1'b0;
          for (int j = 0; j < NREG; j++)
            if (a[j] == cand) taken = 1'b1;
          if (!found && !taken) begin
            a[i]  = cand;
            found = 1'b1;
          end
        end
      end
    end
    return a[r];
  endfunction
endpackage

// File: rtl/rf_addr_dec.sv
module rf_addr_dec
  import csr_bank_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            cs_i,
  input  logic            rnw_i,
  output logic [NREG-1:0] hit_o,
  output logic [NREG-1:0] we_o,
  output logic            rd_en_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_cmp
    localparam logic [AW-1:0] ADDR = reg_addr(r);
    assign hit_o[r] = (addr_i == ADDR);
    assign we_o[r]  = hit_o[r] & cs_i & ~rnw_i;
  end
  assign rd_en_o = cs_i & rnw_i;

  AST_HIT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o)); // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|we_o) |-> (cs_i && !rnw_i)); // R3
endmodule

// File: rtl/rf_reg_slot.sv
module rf_reg_slot
  import csr_bank_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] WMASK   = '0,
  parameter logic [DW-1:0] SCMASK  = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] ld_m_i,
  input  logic [DW-1:0] ld_d_i,
  output logic [DW-1:0] q_o,
  output logic          wstb_o
);
  localparam bit HAS_WR = (WMASK != '0);

  logic [DW-1:0] q_n;

  always_comb begin
    q_n = q_o & ~SCMASK;
    if (we_i) q_n = (q_n & ~WMASK) | (wdata_i & WMASK);
    q_n = (q_n & ~ld_m_i) | (ld_d_i & ld_m_i);  // logic side wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= RST_VAL;
      wstb_o <= 1'b0;
    end else begin
      q_o    <= q_n;
      wstb_o <= we_i & HAS_WR;
    end
  end

  AST_SC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((q_o & SCMASK) == '0)); // R6
  AST_STB_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && HAS_WR) |=> wstb_o); // R5
  AST_STB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !wstb_o); // R5
  AST_RO_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_m_i == '0) |=> ((q_o & ~WMASK) == $past(q_o & ~WMASK))); // R4
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux
  import csr_bank_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NREG-1:0][DW-1:0]  q_i,
  input  logic [NREG-1:0]          hit_i,
  input  logic                     rd_en_i,
  output logic [DW-1:0]            rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NREG; r++)
      if (rd_en_i && hit_i[r]) rdata_o |= q_i[r] & rd_mask(r);
  end

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0)); // R8
  AST_RD_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i == '0) |-> (rdata_o == '0)); // R10
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    cs_i,
  input  logic                    rnw_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [NREG-1:0][DW-1:0] hw_val_o,
  output logic [NREG-1:0]         hw_wstb_o,
  input  logic [NFLD-1:0]         hw_ld_i,
  input  logic [NFLD-1:0][DW-1:0] hw_ld_val_i
);
  logic [NREG-1:0]         hit, we;
  logic                    rd_en;
  logic [NREG-1:0][DW-1:0] q, ld_m, ld_d;

  rf_addr_dec u_dec (
    .clk_i, .rst_ni, .addr_i, .cs_i, .rnw_i,
    .hit_o(hit), .we_o(we), .rd_en_o(rd_en)
  );

  // per-field loads folded into per-register masks
  always_comb begin
    ld_m = '0;
    ld_d = '0;
    for (int f = 0; f < NFLD; f++) begin
      if (FLD_ACC[f] == ACC_RO && hw_ld_i[f]) begin
        ld_m[FLD_REG[f]] |= fld_mask(f);
        ld_d[FLD_REG[f]] |= (hw_ld_val_i[f] << FLD_LSB[f]) & fld_mask(f);
      end
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [DW-1:0] WM = wr_mask(r);
    rf_reg_slot #(
      .RST_VAL(REG_RST[r]), .WMASK(WM), .SCMASK(sc_mask(r))
    ) u_slot (
      .clk_i, .rst_ni,
      .we_i(we[r]), .wdata_i,
      .ld_m_i(ld_m[r]), .ld_d_i(ld_d[r]),
      .q_o(q[r]), .wstb_o(hw_wstb_o[r])
    );
    assign hw_val_o[r] = q[r] & WM;
  end

  rf_rd_mux u_rd (
    .clk_i, .rst_ni, .q_i(q), .hit_i(hit), .rd_en_i(rd_en), .rdata_o
  );
endmodule

// File: tb/csr_bank_bench.sv
module csr_bank_bench;
  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [31:0]         addr_i = '0;
  logic                cs_i = 1'b0;
  logic                rnw_i = 1'b0;
  logic [31:0]         wdata_i = '0;
  logic [31:0]         rdata_o;
  logic [3:0][31:0]    hw_val_o;
  logic [3:0]          hw_wstb_o;
  logic [7:0]          hw_ld_i = '0;
  logic [7:0][31:0]    hw_ld_val_i = '0;

  always #4 clk_i = ~clk_i;

  csr_bank u_csr_bank (.*);

  // model tables, index 0 control, 1 status, 2 command, 3 scratch
  localparam logic [31:0] WM [4] = '{32'hFFFF_00F1, 32'h0, 32'h0001_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] RM [4] = '{32'hFFFF_00F1, 32'h0000_01FF, 32'h0, 32'hFFFF_FFFF};
  localparam logic [31:0] SC [4] = '{32'h1, 32'h0, 32'h0001_0000, 32'h0};
  localparam logic [31:0] RV [4] = '{32'h50, 32'h100, 32'h0, 32'hDEAD_BEEF};

  logic [31:0] qm [4];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int dec(input logic [31:0] a);
    case (a)
      32'h0:  return 1;
      32'h4:  return 0;
      32'h8:  return 2;
      32'h10: return 3;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic step(input string tag, input logic cs, input logic rnw,
                      input logic [31:0] a, input logic [31:0] d,
                      input logic [7:0] ld, input logic [7:0][31:0] lv);
    int idx;
    logic [31:0] nxt [4];
    logic [3:0]  es;
    @(negedge clk_i);
    cs_i = cs; rnw_i = rnw; addr_i = a; wdata_i = d;
    hw_ld_i = ld; hw_ld_val_i = lv;
    #1;
    idx = dec(a);
    chk(tag, rdata_o, (cs && rnw && idx >= 0) ? (qm[idx] & RM[idx]) : 32'h0); // R8
    @(posedge clk_i);
    #1;
    es = '0;
    for (int r = 0; r < 4; r++) begin
      nxt[r] = qm[r] & ~SC[r];
      if (cs && !rnw && idx == r) begin
        nxt[r] = (nxt[r] & ~WM[r]) | (d & WM[r]);
        es[r]  = (WM[r] != 0);
      end
    end
    if (ld[3]) nxt[1] = (nxt[1] & ~32'hFF)  | (lv[3] & 32'hFF);        // R7
    if (ld[4]) nxt[1] = (nxt[1] & ~32'h100) | ((lv[4] & 32'h1) << 8);  // R7
    for (int r = 0; r < 4; r++) begin
      qm[r] = nxt[r];
      chk("R9 hw_val", hw_val_o[r], qm[r] & WM[r]);
    end
    chk("R5 strobe", {28'h0, hw_wstb_o}, {28'h0, es});
  endtask

  task automatic rd(input string tag, input logic [31:0] a);
    step(tag, 1'b1, 1'b1, a, 32'h0, 8'h0, '0);
  endtask

  task automatic wr(input string tag, input logic [31:0] a, input logic [31:0] d);
    step(tag, 1'b1, 1'b0, a, d, 8'h0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0][31:0] lv;
    logic [3:0][31:0] snap;
    void'($urandom(32'd2024));
    for (int r = 0; r < 4; r++) qm[r] = RV[r];
    // R1: reset state, observed during reset
    #20;
    cs_i = 1'b1; rnw_i = 1'b1;
    for (int r = 0; r < 4; r++) chk("R1 hw_val in reset", hw_val_o[r], RV[r] & WM[r]);
    addr_i = 32'h10; #1; chk("R1 scratch read in reset", rdata_o, 32'hDEAD_BEEF);
    addr_i = 32'h0;  #1; chk("R1 status read in reset", rdata_o, 32'h100);
    chk("R1 strobes in reset", {28'h0, hw_wstb_o}, 32'h0);
    cs_i = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    // R2: map
    rd("R2 read 0x4", 32'h4);
    rd("R2 read 0x10", 32'h10);
    rd("R2 read 0x0", 32'h0);
    // R4: status ignores bus write
    wr("R4 write status", 32'h0, 32'hFFFF_FFFF);
    rd("R4 status read", 32'h0);
    chk("R4 status after write", qm[1], 32'h100);
    // R3/R6: control write with pulse bit
    wr("R3 write control", 32'h4, 32'h1234_5671);
    chk("R3 control bits", hw_val_o[0], 32'h1234_0071);
    chk("R5 control strobe", {28'h0, hw_wstb_o}, 32'h1);
    step("R6 idle", 1'b0, 1'b0, 32'h4, 32'h0, 8'h0, '0);
    chk("R6 pulse cleared", hw_val_o[0], 32'h1234_0070);
    chk("R5 strobe dropped", {28'h0, hw_wstb_o}, 32'h0);
    rd("R3 control read", 32'h4);
    // R10: unmapped
    snap = hw_val_o;
    wr("R10 write 0xC", 32'hC, 32'hFFFF_FFFF);
    for (int r = 0; r < 4; r++) chk("R10 unchanged", hw_val_o[r], snap[r]);
    chk("R10 no strobe", {28'h0, hw_wstb_o}, 32'h0);
    rd("R10 read 0xC", 32'hC);
    rd("R10 read 0x14", 32'h14);
    // R7: load wins alongside a bus write to status, oversize value truncated
    lv = '0; lv[3] = 32'h0000_01AB; lv[4] = 32'hFFFF_FFFF; lv[0] = 32'hFFFF_FFFF;
    step("R7 load", 1'b1, 1'b0, 32'h0, 32'h0, 8'h19, lv);
    chk("R7 control untouched by ld[0]", hw_val_o[0], 32'h1234_0070);
    rd("R7 status read", 32'h0);
    chk("R7 status value", qm[1], 32'h1AB);
    // R6/R8: command write-only with pulse
    wr("R6 write command", 32'h8, 32'hFFFF_FFFF);
    chk("R6 kick visible", hw_val_o[2], 32'h0001_FFFF);
    rd("R8 command reads zero", 32'h8);
    chk("R6 kick cleared", hw_val_o[2], 32'h0000_FFFF);
    // R3: cs low write has no effect
    step("R3 cs low", 1'b0, 1'b0, 32'h10, 32'h0, 8'h0, '0);
    chk("R3 scratch kept", hw_val_o[3], 32'hDEAD_BEEF);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      case ($urandom % 6)
        0: a = 32'h0;
        1: a = 32'h4;
        2: a = 32'h8;
        3: a = 32'hC;
        4: a = 32'h10;
        default: a = 32'h14;
      endcase
      for (int f = 0; f < 8; f++) lv[f] = $urandom;
      step("R8 random", ($urandom % 4) != 0, $urandom % 2, a, $urandom,
           (($urandom % 3) == 0) ? 8'($urandom) : 8'h0, lv);
    end
    for (int r = 0; r < 5; r++) rd("R3 final readback", dec(32'h0) >= 0 ? 32'(r * 4) : 32'h0);
    done = 1;
    summary();
  end
endmodule